// File: doc/BRIEF.md
# Threaded Wordcode Fetch and Dispatch Unit

This unit runs the inner loop of a threaded stack-machine interpreter in hardware. It holds an instruction pointer into byte-addressed program memory and reads one 16-bit wordcode per fetch cycle. It does not decode an opcode field. It classifies each raw code with a fixed chain of magnitude and bit tests, and then does one of six things: it hands a native routine address to an external executor, pushes an embedded literal, takes or skips a conditional relative jump, pushes the address of a task register, or enters a high-level routine with or without saving the return point.

The unit holds the top of the data stack in a register. The entries below it sit in a small LIFO. Return points sit in a second LIFO. A native routine is started with a request/done handshake. When the executor finishes, it can ask for a return, which pops the return LIFO into the pointer. Pushing onto a full LIFO or popping an empty one latches an error and stops all activity until reset.

Top module: `wd_dispatch`

## Requirements
- R1: The unit leaves reset in the fetch state with the pointer at `RESET_IP` (default 0), the top of stack at 0 and `err` low. In the fetch state it presents the pointer on `mem_addr` with `mem_rd` high. For every non-branching code it advances the pointer by 2.
- R2: A code whose bits [15:9] are all zero is a native dispatch. `nat_req` rises with `nat_addr` equal to code[8:0]. Both hold and no fetch happens until a cycle with `nat_done` high. If `nat_ret` is low in that cycle, fetching resumes at the next code.
- R3: A code with bit 15 set pushes the old top of stack and makes code[14:0], zero-extended, the new top of stack.
- R4: A code from 0x0200 up to 0x7EFF is a conditional jump. code[6:0] is a distance in words, and the unit doubles it to get bytes. Bit 7 set means the distance is subtracted from the advanced pointer; bit 7 clear means it is added. The jump is taken only when the top of stack is zero; otherwise the pointer simply advances by 2.
- R5: A conditional jump pops the data stack into the top of stack whether it is taken or not.
- R6: A code from 0x7F00 up to `reg_thresh`-1 pushes `reg_base` + code[7:0] as the new top of stack. `reg_thresh` must lie in 0x7F00..0x8000.
- R7: A code from `reg_thresh` up to 0x7FFF with bit 0 clear saves the advanced pointer on the return stack and jumps to the code. A native completion with `nat_ret` high later pops that value into the pointer.
- R8: A call code with bit 0 set jumps to the code with bit 0 cleared and does not touch the return stack.
- R9: A push onto a full LIFO or a pop from an empty one sets `err`, which stays high until reset. While `err` is high, `mem_rd` and `nat_req` are held low. Both LIFOs hold 16 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_thresh | input | 16 | First code value treated as a call (0x7F00..0x8000) |
| reg_base | input | 16 | Base address added to task register offsets |
| mem_rd | output | 1 | Fetch strobe; high in the fetch state |
| mem_addr | output | 16 | Byte address of the wordcode being fetched |
| mem_rdata | input | 16 | Wordcode at `mem_addr`, valid in the same cycle |
| nat_req | output | 1 | Native routine request |
| nat_addr | output | 9 | Native routine address |
| nat_done | input | 1 | Native routine finished |
| nat_ret | input | 1 | With `nat_done`: return from the high-level routine |
| tos | output | 16 | Current top of data stack |
| err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench checks jumps taken forward and backward. A design that added the distance without doubling it, or that ignored bit 7, would fetch from the wrong addresses. It checks a jump that is not taken but still pops its flag. A design that kept the flag would leave the wrong value on top of the stack. It checks a call that saves its return point followed by a return, and a call that does not save followed by a return that must underflow. A design that saved on both kinds of call would resume fetching instead of raising `err`. Seventeen literal pushes must overflow at exactly the seventeenth, with the sixteenth value left on top.

// File: rtl/wd_pkg.sv
package wd_pkg;
    localparam int CODE_W      = 16;
    localparam int NAT_W       = 9;
    localparam logic [CODE_W-1:0] JUMP_LIMIT = 16'h7F00;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_WAIT,
        ST_HALT
    } wd_state_e;

    typedef enum logic [2:0] {
        CL_NATIVE,
        CL_LIT,
        CL_JUMP,
        CL_REG,
        CL_CALL
    } wd_class_e;
endpackage

// File: rtl/wd_decode.sv
module wd_decode
    import wd_pkg::*;
#(
    parameter int DW   = 16,
    parameter int IP_W = 16
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] reg_thresh,
    input  logic [DW-1:0]     reg_base,
    output wd_class_e         cls,
    output logic [NAT_W-1:0]  nat_addr,
    output logic [DW-1:0]     lit_val,
    output logic [DW-1:0]     reg_val,
    output logic              jmp_back,
    output logic [IP_W-1:0]   jmp_disp,
    output logic              call_save,
    output logic [IP_W-1:0]   call_tgt
);
    // fixed priority: native, literal, jump, register, call
    always_comb begin
        if (code[CODE_W-1:NAT_W] == '0)
            cls = CL_NATIVE;
        else if (code[CODE_W-1])
            cls = CL_LIT;
        else if (code < JUMP_LIMIT)
            cls = CL_JUMP;
        else if (code < reg_thresh)
            cls = CL_REG;
        else
            cls = CL_CALL;
    end

    assign nat_addr  = code[NAT_W-1:0];
    assign lit_val   = DW'(code[CODE_W-2:0]);
    assign reg_val   = DW'(code[7:0]) + reg_base;
    assign jmp_back  = code[7];
    assign jmp_disp  = IP_W'({code[6:0], 1'b0});
    assign call_save = ~code[0];
    assign call_tgt  = IP_W'({code[CODE_W-1:1], 1'b0});
endmodule

// File: rtl/wd_lifo.sv
module wd_lifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] top_c;

    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign top_c = cnt_q - CW'(1);
    assign rdata = mem_q[top_c[AW-1:0]];

    always_comb begin
        cnt_d = cnt_q;
        if (push && !full)
            cnt_d = cnt_q + CW'(1);
        else if (pop && !empty)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (push && !full)
            mem_q[cnt_q[AW-1:0]] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wd_dispatch.sv
module wd_dispatch
    import wd_pkg::*;
#(
    parameter int DW       = 16,
    parameter int IP_W     = 16,
    parameter int DS_DEPTH = 16,
    parameter int RS_DEPTH = 16,
    parameter logic [15:0] RESET_IP = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       reg_thresh,
    input  logic [DW-1:0]     reg_base,
    output logic              mem_rd,
    output logic [IP_W-1:0]   mem_addr,
    input  logic [15:0]       mem_rdata,
    output logic              nat_req,
    output logic [8:0]        nat_addr,
    input  logic              nat_done,
    input  logic              nat_ret,
    output logic [DW-1:0]     tos,
    output logic              err
);
    typedef struct packed {
        logic [IP_W-1:0]  ip;
        logic [DW-1:0]    tos;
        wd_state_e        st;
        logic [NAT_W-1:0] nat;
    } regs_t;

    regs_t r_d, r_q;

    wd_class_e        cls;
    logic [NAT_W-1:0] dec_nat;
    logic [DW-1:0]    dec_lit, dec_reg;
    logic             dec_back, dec_save;
    logic [IP_W-1:0]  dec_disp, dec_tgt;

    logic             ds_push, ds_pop, ds_full, ds_empty;
    logic [DW-1:0]    ds_wdata, ds_top;
    logic             rs_push, rs_pop, rs_full, rs_empty;
    logic [IP_W-1:0]  rs_wdata, rs_top;
    logic [IP_W-1:0]  ip_inc;

    wd_decode #(.DW(DW), .IP_W(IP_W)) u_dec (
        .code      (mem_rdata),
        .reg_thresh(reg_thresh),
        .reg_base  (reg_base),
        .cls       (cls),
        .nat_addr  (dec_nat),
        .lit_val   (dec_lit),
        .reg_val   (dec_reg),
        .jmp_back  (dec_back),
        .jmp_disp  (dec_disp),
        .call_save (dec_save),
        .call_tgt  (dec_tgt)
    );

    wd_lifo #(.W(DW), .DEPTH(DS_DEPTH)) u_dstack (
        .clk  (clk),
        .rst_n(rst_n),
        .push (ds_push),
        .pop  (ds_pop),
        .wdata(ds_wdata),
        .rdata(ds_top),
        .full (ds_full),
        .empty(ds_empty)
    );

    wd_lifo #(.W(IP_W), .DEPTH(RS_DEPTH)) u_rstack (
        .clk  (clk),
        .rst_n(rst_n),
        .push (rs_push),
        .pop  (rs_pop),
        .wdata(rs_wdata),
        .rdata(rs_top),
        .full (rs_full),
        .empty(rs_empty)
    );

    assign ip_inc = r_q.ip + IP_W'(2);

    always_comb begin
        r_d      = r_q;
        ds_push  = 1'b0;
        ds_pop   = 1'b0;
        ds_wdata = r_q.tos;
        rs_push  = 1'b0;
        rs_pop   = 1'b0;
        rs_wdata = ip_inc;
        unique case (r_q.st)
            ST_FETCH: begin
                r_d.ip = ip_inc;
                unique case (cls)
                    CL_NATIVE: begin
                        r_d.nat = dec_nat;
                        r_d.st  = ST_WAIT;
                    end
                    CL_LIT, CL_REG: begin
                        if (ds_full) begin
                            r_d.ip = r_q.ip;
                            r_d.st = ST_HALT;
                        end else begin
                            ds_push = 1'b1;
                            r_d.tos = (cls == CL_LIT) ? dec_lit : dec_reg;
                        end
                    end
                    CL_JUMP: begin
                        if (ds_empty) begin
                            r_d.ip = r_q.ip;
                            r_d.st = ST_HALT;
                        end else begin
                            ds_pop  = 1'b1;
                            r_d.tos = ds_top;
                            if (r_q.tos == '0)
                                r_d.ip = dec_back ? (ip_inc - dec_disp)
                                                  : (ip_inc + dec_disp);
                        end
                    end
                    CL_CALL: begin
                        if (dec_save && rs_full) begin
                            r_d.ip = r_q.ip;
                            r_d.st = ST_HALT;
                        end else begin
                            rs_push = dec_save;
                            r_d.ip  = dec_tgt;
                        end
                    end
                    default: r_d.st = ST_HALT;
                endcase
            end
            ST_WAIT: begin
                if (nat_done) begin
                    if (!nat_ret) begin
                        r_d.st = ST_FETCH;
                    end else if (rs_empty) begin
                        r_d.st = ST_HALT;
                    end else begin
                        rs_pop = 1'b1;
                        r_d.ip = rs_top;
                        r_d.st = ST_FETCH;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ip  <= IP_W'(RESET_IP);
            r_q.tos <= '0;
            r_q.st  <= ST_FETCH;
            r_q.nat <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd   = (r_q.st == ST_FETCH);
    assign mem_addr = r_q.ip;
    assign nat_req  = (r_q.st == ST_WAIT);
    assign nat_addr = r_q.nat;
    assign tos      = r_q.tos;
    assign err      = (r_q.st == ST_HALT);
endmodule

// File: rtl/wd_dispatch_chk.sv
module wd_dispatch_chk #(
    parameter int DW   = 16,
    parameter int IP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_rd,
    input logic [IP_W-1:0] mem_addr,
    input logic [15:0]     mem_rdata,
    input logic            nat_req,
    input logic [8:0]      nat_addr,
    input logic            nat_done,
    input logic [DW-1:0]   tos,
    input logic            err
);
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && err |=> err);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_rd && !nat_req);

    // R2
    native_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && nat_req && !nat_done |=> nat_req && $stable(nat_addr));

    // R2
    no_fetch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nat_req |-> !mem_rd);

    // R3
    lit_tos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && mem_rd && mem_rdata[15] |=>
            err || tos == DW'($past(mem_rdata[14:0])));

    // R1
    lit_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && mem_rd && mem_rdata[15] |=>
            err || mem_addr == $past(mem_addr) + IP_W'(2));
endmodule

bind wd_dispatch wd_dispatch_chk #(.DW(DW), .IP_W(IP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .mem_rdata(mem_rdata),
    .nat_req  (nat_req),
    .nat_addr (nat_addr),
    .nat_done (nat_done),
    .tos      (tos),
    .err      (err)
);

// File: tb/wd_dispatch_bench.sv
module wd_dispatch_bench;
    localparam logic [15:0] THRESH = 16'h7F80;
    localparam logic [15:0] BASE   = 16'h1000;
    localparam logic [8:0]  STOP   = 9'h1F0;
    localparam logic [8:0]  RETN   = 9'h1FF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        nat_req;
    logic [8:0]  nat_addr;
    logic        nat_done;
    logic        nat_ret;
    logic [15:0] tos;
    logic        err;

    always #5 clk = ~clk;

    wd_dispatch u_wd_dispatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_thresh(THRESH),
        .reg_base  (BASE),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .nat_req   (nat_req),
        .nat_addr  (nat_addr),
        .nat_done  (nat_done),
        .nat_ret   (nat_ret),
        .tos       (tos),
        .err       (err)
    );

    // program memory, byte addressed, absent words read as a stop dispatch
    logic [15:0] mem [int];
    int          gen = 0;

    function automatic logic [15:0] rd(logic [15:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return {7'd0, STOP};
    endfunction

    always @(mem_addr or gen) mem_rdata = rd(mem_addr);

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference
    logic [15:0] m_ip, m_tos;
    logic [8:0]  m_nat;
    int          m_st;        // 0 fetch, 1 wait, 2 halt
    logic [15:0] m_ds[$];
    logic [15:0] m_rs[$];
    int          wcnt;
    logic [15:0] got[$];
    logic [15:0] exp_f[$];

    task automatic model_step();
        logic [15:0] c, nip, d, f;
        if (m_st == 0) begin
            c   = rd(m_ip);
            nip = m_ip + 16'd2;
            if (c[15:9] == 7'd0) begin
                m_nat = c[8:0]; m_st = 1; m_ip = nip;
            end else if (c[15]) begin
                if (m_ds.size() == 16) m_st = 2;
                else begin m_ds.push_back(m_tos); m_tos = c & 16'h7FFF; m_ip = nip; end
            end else if (c < 16'h7F00) begin
                if (m_ds.size() == 0) m_st = 2;
                else begin
                    f = m_tos; m_tos = m_ds.pop_back();
                    d = (c & 16'h007F) * 16'd2;
                    if (f == 16'd0) m_ip = c[7] ? nip - d : nip + d;
                    else            m_ip = nip;
                end
            end else if (c < THRESH) begin
                if (m_ds.size() == 16) m_st = 2;
                else begin m_ds.push_back(m_tos); m_tos = (c & 16'h00FF) + BASE; m_ip = nip; end
            end else if (!c[0]) begin
                if (m_rs.size() == 16) m_st = 2;
                else begin m_rs.push_back(nip); m_ip = c; end
            end else begin
                m_ip = c & 16'hFFFE;
            end
        end else if (m_st == 1) begin
            if (nat_done) begin
                if (!nat_ret) m_st = 0;
                else if (m_rs.size() == 0) m_st = 2;
                else begin m_ip = m_rs.pop_back(); m_st = 0; end
            end
        end
    endtask

    task automatic compare();
        chk("R1 mem_rd", mem_rd, m_st == 0);
        if (m_st == 0) chk("R1 mem_addr", mem_addr, m_ip);
        chk("R2 nat_req", nat_req, m_st == 1);
        if (m_st == 1) chk("R2 nat_addr", nat_addr, m_nat);
        chk("R3 tos", tos, m_tos);
        chk("R9 err", err, m_st == 2);
        if (mem_rd) got.push_back(mem_addr);
    endtask

    task automatic drive();
        nat_done = 1'b0;
        nat_ret  = 1'b0;
        if (m_st == 1) begin
            wcnt++;
            if (wcnt == 2) begin
                nat_done = 1'b1;
                nat_ret  = (m_nat == RETN);
                wcnt     = 0;
            end
        end
    endtask

    task automatic run_prog(string tag);
        int cyc;
        @(negedge clk);
        rst_n    = 1'b0;
        nat_done = 1'b0;
        nat_ret  = 1'b0;
        m_ip = 16'd0; m_tos = 16'd0; m_st = 0; m_nat = 9'd0;
        m_ds.delete(); m_rs.delete(); got.delete(); wcnt = 0;
        gen++;
        @(negedge clk);
        // R10-style reset view is covered under R1
        chk("R1 reset mem_addr", mem_addr, 16'h0000);
        chk("R1 reset tos", tos, 16'h0000);
        chk("R1 reset err", err, 1'b0);
        chk("R1 reset mem_rd", mem_rd, 1'b1);
        got.push_back(mem_addr);
        rst_n = 1'b1;
        drive();
        model_step();
        cyc = 0;
        forever begin
            @(negedge clk);
            compare();
            if (m_st == 2) break;
            if (m_st == 1 && m_nat == STOP) break;
            drive();
            model_step();
            cyc++;
            if (cyc > 400) begin
                chk({"watchdog ", tag}, 0, 1);
                break;
            end
        end
        chk({tag, " fetch count"}, got.size(), exp_f.size());
        foreach (exp_f[i])
            if (i < got.size()) chk({tag, " fetch addr"}, got[i], exp_f[i]);
    endtask

    initial begin
        #1ms;
        chk("watchdog global", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        nat_done = 1'b0;
        nat_ret  = 1'b0;
        repeat (2) @(negedge clk);

        // literals, forward taken jump, untaken jump, register push (R3 R4 R5 R6)
        mem.delete();
        mem[0]  = 16'h8005; mem[2] = 16'h8000; mem[4] = 16'h0202;
        mem[6]  = 16'h8063; mem[8] = 16'h8063; mem[10] = 16'h0281;
        mem[12] = 16'h7F05; mem[14] = {7'd0, STOP};
        exp_f = '{16'd0, 16'd2, 16'd4, 16'd10, 16'd12, 16'd14};
        run_prog("R4 fwd");
        chk("R6 register push", tos, 16'h1005);
        chk("R2 stop address", nat_addr, STOP);

        // forward then backward taken jumps, native dispatch (R2 R4)
        mem.delete();
        mem[0]  = 16'h8000; mem[2] = 16'h0203; mem[4] = 16'h0111;
        mem[6]  = {7'd0, STOP}; mem[10] = 16'h8000; mem[12] = 16'h0285;
        exp_f = '{16'd0, 16'd2, 16'd10, 16'd12, 16'd4, 16'd6};
        run_prog("R4 back");
        chk("R5 flag popped", tos, 16'h0000);
        chk("R2 no error", err, 1'b0);

        // untaken jump still discards its flag (R5)
        mem.delete();
        mem[0] = 16'h8009; mem[2] = 16'h8003; mem[4] = 16'h0201;
        mem[6] = {7'd0, STOP};
        exp_f = '{16'd0, 16'd2, 16'd4, 16'd6};
        run_prog("R5 untaken");
        chk("R5 discard untaken", tos, 16'h0009);

        // saving call, return, non-saving call, return underflows (R7 R8 R9)
        mem.delete();
        mem[0]       = 16'h7F80;
        mem[16'h7F80] = 16'h8042; mem[16'h7F82] = {7'd0, RETN};
        mem[2]       = 16'h7F91;
        mem[16'h7F90] = 16'h8055; mem[16'h7F92] = {7'd0, RETN};
        exp_f = '{16'd0, 16'h7F80, 16'h7F82, 16'd2, 16'h7F90, 16'h7F92};
        run_prog("R7 R8 call");
        chk("R8 no save then underflow", err, 1'b1);
        chk("R8 tos", tos, 16'h0055);
        @(negedge clk);
        chk("R9 halted no fetch", mem_rd, 1'b0);
        chk("R9 halted no request", nat_req, 1'b0);

        // data stack overflow on the seventeenth push (R9)
        mem.delete();
        for (int i = 0; i < 17; i++) mem[2 * i] = 16'h8000 + 16'(i);
        exp_f.delete();
        for (int i = 0; i < 17; i++) exp_f.push_back(16'(2 * i));
        run_prog("R9 overflow");
        chk("R9 overflow err", err, 1'b1);
        chk("R9 overflow tos", tos, 16'h000F);
        repeat (3) @(negedge clk);
        chk("R9 err sticky", err, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule